// File: doc/BRIEF.md
# Audio Clock Divider with Retiming

This block turns one master clock, running at 256 times the audio sample rate, into the three clocks a serial audio link needs: a converter master clock at half the input rate, a bit clock at a quarter of it, and a word-select (left/right) clock at the sample rate. For example, a 49.152 MHz input gives 24.576 MHz, 12.288 MHz and 192 kHz. All three are taken from a single free-running synchronous binary counter, so their ratios are fixed and cannot drift against each other.

None of the counter bits drives an output pin directly. The counter taps and the serial data returned by a converter all pass through one shared output register on the master clock. Every output therefore changes on the same master edge, and the data stays aligned with the clocks that frame it. A synchronous, active-high reset clears the counter and the output register together, which restarts the framing from a known phase.

Top module: `audio_clkgen`

## Requirements
- R1: While `rst_i` is high at a rising `clk_i` edge, every output (`mclk_o`, `bclk_o`, `wsel_o`, `sdata_o`) is 0 after that edge.
- R2: Counting rising edges after reset release as 1, 2, 3 and so on, `mclk_o` after edge k equals bit 0 of (k-1). It has a period of 2 input cycles and a 50 % duty cycle.
- R3: `bclk_o` after edge k equals bit 1 of (k-1). It has a period of 4 input cycles and a 50 % duty cycle, and it changes only on edges where `mclk_o` goes from 1 to 0.
- R4: `wsel_o` after edge k equals bit 7 of (k-1). It has a period of 256 input cycles and stays high for exactly 128 cycles at a time.
- R5: `wsel_o` changes only on an edge where `bclk_o` goes from 1 to 0.
- R6: Each clock output lags its counter bit by exactly one input cycle. As a result, `wsel_o` first goes high on edge 129 after reset release, and `mclk_o` first goes high on edge 2.
- R7: `sdata_o` after a rising edge equals the value `sdata_i` had at that edge, unless reset is active at that edge.
- R8: Asserting reset in the middle of a frame restarts all three clocks from the phase defined in R2 to R6, counted from the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master input clock at 256 times the sample rate |
| rst_i | input | 1 | Synchronous reset, active high |
| sdata_i | input | 1 | Serial data from the converter |
| mclk_o | output | 1 | Registered master clock output, input rate divided by 2 |
| bclk_o | output | 1 | Registered bit clock, input rate divided by 4 |
| wsel_o | output | 1 | Registered word-select clock, input rate divided by 256 |
| sdata_o | output | 1 | Serial data registered in the same stage as the clocks |

## Verification
The assertions expect the first rising edge they evaluate to be one where reset is high. They also expect reset to stay high for at least one full edge, so that every phase relation is measured from a known start. The stimulus begins with reset held for several cycles and drives reset and `sdata_i` only on falling clock edges, so both are stable at every rising edge. The serial data comes from a free-running pseudo-random sequence, which exercises the retiming with both levels and with runs of equal bits. The mid-frame reset is released at a point where the counter is far from zero, so the restart is clearly different from simply carrying on.

// File: rtl/acd_pkg.sv
package acd_pkg;

  // Default counter width: 256 input cycles per frame
  localparam int unsigned ACD_CNT_W = 8;

  // Bundle of outputs captured in the shared retiming stage
  typedef struct packed {
    logic mclk;
    logic bclk;
    logic wsel;
    logic sdat;
  } acd_lane_t;

  localparam int unsigned ACD_LANE_W = $bits(acd_lane_t);

endpackage

// File: rtl/acd_counter.sv
module acd_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  // Free-running synchronous binary count; wraps naturally
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/acd_retime.sv
module acd_retime #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r;

  // One flop per lane, all on the same master edge
  for (genvar g = 0; g < W; g++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        q_r[g] <= 1'b0;
      end else begin
        q_r[g] <= d_i[g];
      end
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int unsigned CNT_W    = acd_pkg::ACD_CNT_W,
  parameter int unsigned MCLK_TAP = 0,
  parameter int unsigned BCLK_TAP = 1,
  parameter int unsigned WSEL_TAP = CNT_W - 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sdata_i,
  output logic mclk_o,
  output logic bclk_o,
  output logic wsel_o,
  output logic sdata_o
);
  import acd_pkg::*;

  logic [CNT_W-1:0]      cnt;
  acd_lane_t             lane_d;
  acd_lane_t             lane_q;
  logic [ACD_LANE_W-1:0] lane_bits;

  acd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .cnt_o (cnt)
  );

  // Taps from the single counter plus the converter data
  always_comb begin
    lane_d.mclk = cnt[MCLK_TAP];
    lane_d.bclk = cnt[BCLK_TAP];
    lane_d.wsel = cnt[WSEL_TAP];
    lane_d.sdat = sdata_i;
  end

  acd_retime #(.W(ACD_LANE_W)) u_rt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (lane_d),
    .q_o   (lane_bits)
  );

  assign lane_q  = acd_lane_t'(lane_bits);
  assign mclk_o  = lane_q.mclk;
  assign bclk_o  = lane_q.bclk;
  assign wsel_o  = lane_q.wsel;
  assign sdata_o = lane_q.sdat;

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic clk_i,
  input logic rst_i,
  input logic sdata_i,
  input logic mclk_o,
  input logic bclk_o,
  input logic wsel_o,
  input logic sdata_o
);

  localparam int unsigned HALF = 1 << (CNT_W - 1);

  logic           armed;
  logic           ws_q;
  logic           seen;
  logic [CNT_W:0] run;

  always_ff @(posedge clk_i) begin
    if (rst_i) armed <= 1'b1;
  end

  // Cycles between word-select toggles, measured without long $past
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ws_q <= 1'b0;
      run  <= '0;
      seen <= 1'b0;
    end else begin
      ws_q <= wsel_o;
      if (wsel_o != ws_q) begin
        run  <= 1;
        seen <= 1'b1;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  // R1: reset leaves all outputs low
  assert_reset_low_R1: assert property (@(posedge clk_i) disable iff (!armed)
    rst_i |=> (!mclk_o && !bclk_o && !wsel_o && !sdata_o));

  // R2: master clock output toggles every cycle once running
  assert_mclk_toggle_R2: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    (!$past(rst_i) && !$past(rst_i, 2)) |-> (mclk_o != $past(mclk_o)));

  // R3: bit clock moves only where master clock falls
  assert_bclk_on_mfall_R3: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    (!$past(rst_i) && bclk_o != $past(bclk_o)) |-> ($past(mclk_o) && !mclk_o));

  // R5: word select moves only where bit clock falls
  assert_wsel_on_bfall_R5: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    (!$past(rst_i) && wsel_o != $past(wsel_o)) |-> ($past(bclk_o) && !bclk_o));

  // R4: word select half period is HALF cycles
  assert_wsel_half_R4: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    (seen && wsel_o != ws_q) |-> (run == HALF));

  // R7: data output is input delayed by one edge
  assert_data_delay_R7: assert property (@(posedge clk_i) disable iff (rst_i || !armed)
    !$past(rst_i) |-> (sdata_o == $past(sdata_i)));

endmodule

bind audio_clkgen audio_clkgen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .sdata_i (sdata_i),
  .mclk_o  (mclk_o),
  .bclk_o  (bclk_o),
  .wsel_o  (wsel_o),
  .sdata_o (sdata_o)
);

// File: tb/audio_clkgen_test.sv
`timescale 1ns/1ps
module audio_clkgen_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdi = 1'b0;
  logic mclk, bclk, wsel, sdo;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  audio_clkgen uut (
    .clk_i   (clk),
    .rst_i   (rst),
    .sdata_i (sdi),
    .mclk_o  (mclk),
    .bclk_o  (bclk),
    .wsel_o  (wsel),
    .sdata_o (sdo)
  );

  // Behavioural reference: edges since release plus a data queue
  int n = 0;
  bit sd_hist[$];

  always @(posedge clk) begin
    if (rst) begin
      n = 0;
      sd_hist.delete();
      sd_hist.push_back(1'b0);
    end else begin
      n = n + 1;
      sd_hist.push_back(sdi);
      if (sd_hist.size() > 1) void'(sd_hist.pop_front());
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s at n=%0d: actual %0d expected %0d", tag, n, act, exp);
    end
  endtask

  // Period trackers
  int  last_m = -1, last_b = -1, last_w = -1, w_hi_start = -1;
  bit  pm = 0, pb = 0, pw = 0;
  bit  first_w_seen = 0;

  task automatic compare_cycle();
    int e_m, e_b, e_w, e_d;
    if (n == 0) begin
      e_m = 0; e_b = 0; e_w = 0; e_d = 0;
      check("R1 mclk", mclk, 0); check("R1 bclk", bclk, 0);
      check("R1 wsel", wsel, 0); check("R1 sdata", sdo, 0);
      last_m = -1; last_b = -1; last_w = -1; w_hi_start = -1;
      first_w_seen = 0;
    end else begin
      e_m = (n - 1) & 1;
      e_b = ((n - 1) >> 1) & 1;
      e_w = ((n - 1) >> 7) & 1;
      e_d = sd_hist[0];
      check("R2/R6 mclk", mclk, e_m);
      check("R3/R6 bclk", bclk, e_b);
      check("R4/R6 wsel", wsel, e_w);
      check("R7 sdata", sdo, e_d);
      if (mclk && !pm) begin
        if (last_m < 0) check("R6 first mclk rise edge", n, 2);
        else check("R2 mclk period", n - last_m, 2);
        last_m = n;
      end
      if (bclk && !bb_prev()) begin
        if (last_b >= 0) check("R3 bclk period", n - last_b, 4);
        last_b = n;
      end
      if (bclk != pb) check("R3 bclk moves with mclk fall", {pm, mclk}, 2);
      if (wsel != pw) check("R5 wsel moves with bclk fall", {pb, bclk}, 2);
      if (wsel && !pw) begin
        if (!first_w_seen) check("R6 first wsel rise edge", n, 129);
        else check("R4 wsel period", n - last_w, 256);
        first_w_seen = 1;
        last_w = n;
        w_hi_start = n;
      end
      if (!wsel && pw && w_hi_start >= 0)
        check("R4 wsel high length", n - w_hi_start, 128);
    end
    pm = mclk; pb = bclk; pw = wsel;
  endtask

  function automatic bit bb_prev();
    return pb;
  endfunction

  bit [15:0] lfsr = 16'hACE1;

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_cycle();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sdi = lfsr[0];
    end
  endtask

  initial begin
    rst = 1'b1;
    run(4);                 // R1 reset state held
    @(negedge clk); rst = 1'b0;
    run(1100);              // several frames, random data
    rst = 1'b1;             // R8 mid-frame reset
    run(3);
    rst = 1'b0;
    run(700);               // R8 restart phase rechecked via R6 rise edges
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule